// File: doc/BRIEF.md
# Serial packet timeout monitor

This block enforces a maximum lifetime on each transaction seen by a two-wire SMBus/PMBus-style slave. A bit-level decoder supplies it with single-cycle event strobes: START, STOP, the end of each received byte with that byte's value, and a flag saying whether the bus was free when a START appeared. A millisecond tick drives its timer. The timer is armed by a START that arrives while the monitor is idle. It keeps running through repeated STARTs, address bytes, the command byte, ACK and direction bits, and data bytes, and it stops at STOP.

The window for a transaction is fixed when its command byte (the second byte after the arming START) completes. The window is long when the extension bit of the configuration word is set, or when the command is the fault-log read command. Otherwise it is short. The short window is never allowed below a floor value. When the window runs out, the monitor forces the slave's SDA and SCL pull-down requests off, so the lines float high, and raises `discard` so the protocol engine drops the message. The monitor stays in that state until the bus frees up again. Because the timer counts milliseconds and not bus clocks, any SCL rate from 10 kHz to 400 kHz fits within the window.

Top module: `pkt_timeout_mon`

## Requirements
- R1: After reset, `busy`, `discard`, `sda_pull` and `scl_hold` are all 0.
- R2: A START while idle sets `busy` in the following cycle. A STOP clears `busy` in the following cycle.
- R3: With the short window W = max(SHORT_MS, MIN_MS), `discard` stays 0 after W ticks since the arming START and rises in the cycle after tick W+1.
- R4: If bit EXT_BIT (default 3) of `cfg` is 1 when the command byte ends, the window is LONG_MS ticks: there is no discard after LONG_MS ticks, and there is a discard after tick LONG_MS+1.
- R5: A command byte equal to LOG_CMD selects the long window even when the extension bit of `cfg` is 0.
- R6: The window is latched when the command byte ends. Later changes to `cfg` within the same transaction do not alter it.
- R7: A START while `busy` (a repeated START) does not restart or reset the tick count.
- R8: While `discard` is 1, `sda_pull` and `scl_hold` are 0. Otherwise they follow `sda_pull_in` and `scl_hold_in`.
- R9: Once set, `discard` holds until a STOP arrives, or until a START arrives with `bus_free`=1. A START with `bus_free`=0 is ignored. A START with `bus_free`=1 re-arms the timer from zero.
- R10: A STOP before expiry ends the transaction with no discard. Ticks that arrive while idle have no effect on the next transaction's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ev_start | input | 1 | START or repeated START detected |
| ev_stop | input | 1 | STOP detected |
| ev_byte_end | input | 1 | A byte (with its ACK slot) has completed |
| byte_val | input | 8 | Value of the completed byte |
| bus_free | input | 1 | Bus was idle when the current START arrived |
| cfg | input | CFG_W | Configuration word; bit EXT_BIT selects the long window |
| sda_pull_in | input | 1 | SDA pull-down request from the protocol engine |
| scl_hold_in | input | 1 | SCL stretch request from the protocol engine |
| sda_pull | output | 1 | Gated SDA pull-down to the pad |
| scl_hold | output | 1 | Gated SCL stretch to the pad |
| busy | output | 1 | A timed transaction is in progress |
| discard | output | 1 | Timed out; the message is being dropped |

## Verification
The bench builds the block with SHORT_MS=4, MIN_MS=6 and LONG_MS=12, and LOG_CMD=8'hA5. With these values the floor overrides the short setting, so the clamp is exercised. Every expiry also lands within a few dozen ticks, which lets each window be probed one tick before and one tick after its edge. The small windows also make it cheap to test repeated STARTs partway through a window, changes to `cfg` after the command byte, and leaving the discard state.

// File: rtl/pkt_timeout_mon.sv
module pkt_timeout_mon #(
  parameter int           SHORT_MS = 30,
  parameter int           LONG_MS  = 255,
  parameter int           MIN_MS   = 25,
  parameter int           CFG_W    = 8,
  parameter int           EXT_BIT  = 3,
  parameter logic [7:0]   LOG_CMD  = 8'hEE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_byte_end,
  input  logic [7:0]       byte_val,
  input  logic             bus_free,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sda_pull_in,
  input  logic             scl_hold_in,
  output logic             sda_pull,
  output logic             scl_hold,
  output logic             busy,
  output logic             discard
);
  localparam int SHORT_EFF = (SHORT_MS < MIN_MS) ? MIN_MS : SHORT_MS;
  localparam int LONG_EFF  = (LONG_MS < SHORT_EFF) ? SHORT_EFF : LONG_MS;
  localparam int CW        = $clog2(LONG_EFF + 1);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_EFF);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_EFF);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DROP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [1:0]    nbyte;
  logic          cmd_byte;
  logic          want_long;

  assign cmd_byte  = ev_byte_end && (nbyte == 2'd1);
  assign want_long = cfg[EXT_BIT] || (byte_val == LOG_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      lim   <= LIM_S;
      nbyte <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (ev_start && !ev_stop) begin
          st    <= ST_RUN;
          cnt   <= '0;
          lim   <= LIM_S;
          nbyte <= '0;
        end
        ST_RUN: if (ev_stop) begin
          st <= ST_IDLE;
        end else begin
          if (ms_tick) begin
            if (cnt == lim) st <= ST_DROP;
            else            cnt <= cnt + 1'b1;
          end
          if (ev_byte_end && nbyte != 2'd2) nbyte <= nbyte + 2'd1;
          if (cmd_byte) lim <= want_long ? LIM_L : LIM_S;
        end
        ST_DROP: if (ev_stop) begin
          st <= ST_IDLE;
        end else if (ev_start && bus_free) begin
          st    <= ST_RUN;
          cnt   <= '0;
          lim   <= LIM_S;
          nbyte <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st == ST_RUN);
  assign discard  = (st == ST_DROP);
  assign sda_pull = sda_pull_in & ~discard;
  assign scl_hold = scl_hold_in & ~discard;

  // R2
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!busy && !discard));

  // R3
  drop_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discard) |-> ($past(ms_tick) && $past(cnt) == $past(lim)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= lim));

  // R6
  lim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_stop && !cmd_byte) |=> $stable(lim));

  // R7
  rep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_start && !ev_stop && !ms_tick) |=> (busy && $stable(cnt)));

  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !ev_stop && !(ev_start && bus_free)) |=> discard);
endmodule

// File: tb/pkt_timeout_mon_tb_top.sv
module pkt_timeout_mon_tb_top;
  localparam logic [7:0] LOGC = 8'hA5;
  localparam int WS = 6;
  localparam int WL = 12;

  logic clk = 0, rst_n = 0;
  logic ms_tick = 0, ev_start = 0, ev_stop = 0, ev_byte_end = 0, bus_free = 1;
  logic [7:0] byte_val = 0, cfg = 0;
  logic sda_pull_in = 0, scl_hold_in = 0;
  logic sda_pull, scl_hold, busy, discard;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pkt_timeout_mon #(.SHORT_MS(4), .LONG_MS(WL), .MIN_MS(WS), .LOG_CMD(LOGC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_end(ev_byte_end), .byte_val(byte_val), .bus_free(bus_free), .cfg(cfg),
    .sda_pull_in(sda_pull_in), .scl_hold_in(scl_hold_in), .sda_pull(sda_pull),
    .scl_hold(scl_hold), .busy(busy), .discard(discard));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic p_start(); @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic p_stop();  @(negedge clk); ev_stop = 1;  @(negedge clk); ev_stop = 0;  endtask
  task automatic p_byte(logic [7:0] v);
    @(negedge clk); ev_byte_end = 1; byte_val = v; @(negedge clk); ev_byte_end = 0;
  endtask
  task automatic p_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1; @(negedge clk); ms_tick = 0;
    end
  endtask
  task automatic open_pkt(logic [7:0] cmd);
    p_start(); p_byte(8'h5A); p_byte(cmd);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 discard", discard, 0);
    chk("R1 sda_pull", sda_pull, 0); chk("R1 scl_hold", scl_hold, 0);
  endtask

  task automatic t_basic();
    p_start(); chk("R2 busy after start", busy, 1);
    p_byte(8'h5A); p_byte(8'h10); p_ticks(WS);
    p_stop(); chk("R2 busy after stop", busy, 0);
    chk("R10 no discard", discard, 0);
    p_ticks(20); chk("R10 idle ticks", busy, 0);
    open_pkt(8'h10); p_ticks(WS);
    chk("R10 idle ticks not counted", discard, 0);
    p_stop();
  endtask

  task automatic t_short();
    cfg = 0; open_pkt(8'h20); p_ticks(WS);
    chk("R3 before edge", discard, 0);
    p_ticks(1); chk("R3 after edge", discard, 1);
    p_stop(); chk("R3 cleared", discard, 0);
  endtask

  task automatic t_ext();
    cfg = 8'h08; open_pkt(8'h20); p_ticks(WL);
    chk("R4 before long edge", discard, 0);
    p_ticks(1); chk("R4 after long edge", discard, 1);
    p_stop(); cfg = 0;
  endtask

  task automatic t_log();
    cfg = 0; open_pkt(LOGC); p_ticks(WL);
    chk("R5 before long edge", discard, 0);
    p_ticks(1); chk("R5 after long edge", discard, 1);
    p_stop();
  endtask

  task automatic t_latch();
    cfg = 0; open_pkt(8'h30); cfg = 8'h08; p_ticks(WS + 1);
    chk("R6 cfg set late", discard, 1); p_stop();
    cfg = 8'h08; open_pkt(8'h30); cfg = 0; p_ticks(WS + 1);
    chk("R6 cfg cleared late", discard, 0); p_stop();
  endtask

  task automatic t_rep();
    cfg = 0; open_pkt(8'h40); p_ticks(4);
    p_start(); p_byte(8'h5B); chk("R7 still busy", busy, 1);
    p_ticks(WS - 4); chk("R7 no restart", discard, 0);
    p_ticks(1); chk("R7 expiry on original count", discard, 1);
    p_stop();
  endtask

  task automatic t_release();
    sda_pull_in = 1; scl_hold_in = 1; open_pkt(8'h50); @(negedge clk);
    chk("R8 sda passes", sda_pull, 1); chk("R8 scl passes", scl_hold, 1);
    p_ticks(WS + 1);
    chk("R8 sda released", sda_pull, 0); chk("R8 scl released", scl_hold, 0);
    p_stop(); @(negedge clk);
    chk("R8 sda restored", sda_pull, 1);
    sda_pull_in = 0; scl_hold_in = 0;
  endtask

  task automatic t_exit();
    open_pkt(8'h60); p_ticks(WS + 1); chk("R9 entered", discard, 1);
    bus_free = 0; p_start(); p_byte(8'h11);
    chk("R9 start on busy bus ignored", discard, 1);
    bus_free = 1; p_start();
    chk("R9 rearm discard", discard, 0); chk("R9 rearm busy", busy, 1);
    p_ticks(WS); chk("R9 fresh count", discard, 0);
    p_ticks(1); chk("R9 fresh expiry", discard, 1);
    p_stop(); chk("R9 stop exits", discard, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset(); t_basic(); t_short(); t_ext(); t_log();
    t_latch(); t_rep(); t_release(); t_exit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule